// File: doc/BRIEF.md
# Interval Timer with Phase-Keeping Tick Rescheduler

This block pairs a free-running cycle counter with a narrower compare register and an engine that reschedules the compare point. The counter advances once per clock. When the low bits of the counter equal the programmed compare value, a pending flag is set. The interrupt output is that pending flag gated by an enable input. Software, or a neighbouring controller, acknowledges each tick. On that acknowledge the engine samples the counter and subtracts the stored expected tick time. It divides the result by the period to learn how many ticks went by. It then picks the next deadline on the original period grid, so the tick phase is kept even when deliveries are late.

Division runs over several cycles. When the elapsed count is less than 32 periods, a short repeated-subtraction loop is used. Otherwise a full shift-and-subtract divider runs. If the next deadline would land too close to the current count, the compare register is given one period more. This stops the counter from passing the compare point before the new value is written, which would delay the tick until the low bits wrap. The stored expected time does not include this extra period, so the next acknowledge counts the skipped tick. A late flag reports catch-up counts larger than a configured ticks-per-second figure.

Top module: `interval_timer`

## Requirements
- R1: `count_o` is 0 during reset and increases by exactly one on every clock edge after reset is released.
- R2: A `start_i` pulse sampled while the engine is not busy, with the counter at C, sets the expected tick time to C+P and programs the compare register with the low CMP_W bits of C+P, where P is `period_i`. The pending flag is set on the edge where the low CMP_W counter bits equal the compare value, so `irq_o` is first seen high with `count_o` equal to that deadline plus one.
- R3: `irq_o` is the pending flag gated by `irq_en_i`. A deadline that passes while `irq_en_i` is 0 keeps `irq_o` low, and the flag is not lost: `irq_o` goes high in the cycle after `irq_en_i` returns to 1.
- R4: An `ack_i` sampled while the engine is idle and started captures the counter as N and clears the pending flag. It reports `ticks_o` = 1 + floor((N − E) / P), where E is the stored expected time.
- R5: With r = (N − E) mod P, the new expected time is N + (P − r). Both division paths give the exact quotient and remainder.
- R6: If P − r is less than SKIP_TH, the compare register is given the new expected time plus P, and `skip_o` is 1. Otherwise it is given the new expected time, and `skip_o` is 0. The stored expected time never includes the extra P.
- R7: `late_o` is 1 exactly when the reported tick count is greater than TICKS_PER_SEC.
- R8: The repeated-subtraction path is taken when (N − E) >> 5 < P. Otherwise the general divider is taken. Both produce the results of R4 to R7.
- R9: `ack_i` has no effect while `busy_o` is 1 or before the first `start_i`. Each accepted acknowledge produces exactly one `done_o` pulse.
- R10: `done_o` is a single-cycle pulse. `ticks_o`, `late_o` and `skip_o` change only with `done_o` and hold their values until the next pulse. In reset, `irq_o`, `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arms the timer one period after the current count |
| ack_i | input | 1 | Tick acknowledge; starts a reschedule |
| irq_en_i | input | 1 | Interrupt mask (1 = deliver) |
| period_i | input | PER_W | Tick period in cycles |
| irq_o | output | 1 | Masked interrupt request |
| count_o | output | CNT_W | Free-running cycle counter |
| ticks_o | output | TICK_W | Ticks elapsed at the last reschedule |
| busy_o | output | 1 | Reschedule in progress |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| late_o | output | 1 | Last tick count exceeded TICKS_PER_SEC |
| skip_o | output | 1 | Last reschedule added a guard period |

## Verification
The bench builds the block with CMP_W = 16, SKIP_TH = 100, TICKS_PER_SEC = 4 and a 300-cycle period. With the small guard, a skip occurs when the bench acknowledges 50 cycles before a period boundary. With the small ticks-per-second value, the late flag needs only about 1500 cycles of delay. An acknowledge delayed by 10000 cycles moves the elapsed count past 32 periods and so drives the general divider, while the shorter delays stay on the subtraction loop. The 16-bit compare keeps every deadline well inside one wrap of the compared bits, so the bench can check each deadline as a full counter value.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_SUB,
        DV_SHIFT
    } div_st_e;

    typedef enum logic [2:0] {
        RS_OFF,
        RS_IDLE,
        RS_DIV,
        RS_WAIT,
        RS_UPD
    } rs_st_e;

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             pend_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CMP_W-1:0] cmp;
        logic             armed;
        logic             pend;
    } ctr_t;

    ctr_t q, d;
    logic hit;

    always_comb begin
        d     = q;
        hit   = q.armed && (q.cnt[CMP_W-1:0] == q.cmp);
        d.cnt = q.cnt + 1'b1;
        if (cmp_we) begin
            d.cmp   = cmp_val;
            d.armed = 1'b1;
        end
        d.pend = (q.pend && !pend_clr) || hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_o = q.cnt;
    assign pend_o  = q.pend;

    // R2: a compare hit always leaves the pending flag set
    a_r2_match_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (q.armed && (q.cnt[CMP_W-1:0] == q.cmp)) |=> pend_o);

endmodule

// File: rtl/itmr_divider.sv
module itmr_divider
    import itmr_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    localparam int IW = $clog2(W + 1);

    typedef struct packed {
        div_st_e       st;
        logic [W-1:0]  num;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [IW-1:0] idx;
        logic          done;
    } dv_t;

    dv_t q, d;
    logic [W:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.num[W-1]};
        case (q.st)
            DV_IDLE: begin
                if (start) begin
                    d.dvs = divisor;
                    d.quo = '0;
                    if ((dividend >> 5) < divisor) begin
                        d.rem = dividend;
                        d.st  = DV_SUB;
                    end else begin
                        d.num = dividend;
                        d.rem = '0;
                        d.idx = IW'(W);
                        d.st  = DV_SHIFT;
                    end
                end
            end
            DV_SUB: begin
                if (q.rem >= q.dvs) begin
                    d.rem = q.rem - q.dvs;
                    d.quo = q.quo + 1'b1;
                end else begin
                    d.done = 1'b1;
                    d.st   = DV_IDLE;
                end
            end
            DV_SHIFT: begin
                if (trial >= {1'b0, q.dvs}) begin
                    d.rem = W'(trial - {1'b0, q.dvs});
                    d.quo = {q.quo[W-2:0], 1'b1};
                end else begin
                    d.rem = trial[W-1:0];
                    d.quo = {q.quo[W-2:0], 1'b0};
                end
                d.num = {q.num[W-2:0], 1'b0};
                d.idx = q.idx - 1'b1;
                if (q.idx == IW'(1)) begin
                    d.done = 1'b1;
                    d.st   = DV_IDLE;
                end
            end
            default: d.st = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= DV_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;
    assign rem_o  = q.rem;

    // R5: a finished division leaves a remainder below the divisor
    a_r5_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (q.dvs != '0)) |-> (rem_o < q.dvs));

endmodule

// File: rtl/itmr_resched.sv
module itmr_resched
    import itmr_pkg::*;
#(
    parameter int CNT_W         = 64,
    parameter int CMP_W         = 32,
    parameter int PER_W         = 32,
    parameter int TICK_W        = 32,
    parameter int SKIP_TH       = 8192,
    parameter int TICKS_PER_SEC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              div_done,
    input  logic [CNT_W-1:0]  div_quo,
    input  logic [CNT_W-1:0]  div_rem,
    output logic              div_start,
    output logic [CNT_W-1:0]  div_dividend,
    output logic [CNT_W-1:0]  div_divisor,
    output logic              cmp_we,
    output logic [CMP_W-1:0]  cmp_val,
    output logic              pend_clr,
    output logic              busy_o,
    output logic              done_o,
    output logic [TICK_W-1:0] ticks_o,
    output logic              late_o,
    output logic              skip_o
);

    localparam logic [CNT_W-1:0] SKIP_V = CNT_W'(SKIP_TH);
    localparam logic [CNT_W-1:0] TPS_V  = CNT_W'(TICKS_PER_SEC);

    typedef struct packed {
        rs_st_e            st;
        logic [CNT_W-1:0]  expt;
        logic [CNT_W-1:0]  now;
        logic [CNT_W-1:0]  quo;
        logic [CNT_W-1:0]  rem;
        logic [PER_W-1:0]  per;
        logic [TICK_W-1:0] ticks;
        logic              late;
        logic              skip;
        logic              done;
    } rs_t;

    rs_t q, d;
    logic [CNT_W-1:0] per_w;
    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] tick_full;
    logic             near;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        cmp_we    = 1'b0;
        cmp_val   = '0;
        pend_clr  = 1'b0;
        div_start = 1'b0;
        per_w     = CNT_W'(q.per);
        left      = per_w - q.rem;
        nxt       = q.now + left;
        near      = left < SKIP_V;
        tick_full = q.quo + 1'b1;

        case (q.st)
            RS_OFF, RS_IDLE: begin
                if (start_i) begin
                    d.per    = period_i;
                    d.expt   = count_i + CNT_W'(period_i);
                    cmp_we   = 1'b1;
                    cmp_val  = CMP_W'(count_i + CNT_W'(period_i));
                    pend_clr = 1'b1;
                    d.st     = RS_IDLE;
                end else if (ack_i && (q.st == RS_IDLE)) begin
                    d.now    = count_i;
                    d.per    = period_i;
                    pend_clr = 1'b1;
                    d.st     = RS_DIV;
                end
            end
            RS_DIV: begin
                div_start = 1'b1;
                d.st      = RS_WAIT;
            end
            RS_WAIT: begin
                if (div_done) begin
                    d.quo = div_quo;
                    d.rem = div_rem;
                    d.st  = RS_UPD;
                end
            end
            RS_UPD: begin
                d.expt  = nxt;
                cmp_we  = 1'b1;
                cmp_val = CMP_W'(nxt + (near ? per_w : {CNT_W{1'b0}}));
                d.ticks = TICK_W'(tick_full);
                d.late  = tick_full > TPS_V;
                d.skip  = near;
                d.done  = 1'b1;
                d.st    = RS_IDLE;
            end
            default: d.st = RS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= RS_OFF;
        end else begin
            q <= d;
        end
    end

    assign div_dividend = q.now - q.expt;
    assign div_divisor  = CNT_W'(q.per);
    assign busy_o       = (q.st == RS_DIV) || (q.st == RS_WAIT) || (q.st == RS_UPD);
    assign done_o       = q.done;
    assign ticks_o      = q.ticks;
    assign late_o       = q.late;
    assign skip_o       = q.skip;

    // R9: a reschedule is only ever entered from the idle state
    a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RS_DIV) |-> ($past(q.st) == RS_IDLE));

    // R4: a reported tick count is never zero
    a_r4_ticks_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ticks_o != '0));

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W         = 64,
    parameter int CMP_W         = 32,
    parameter int PER_W         = 32,
    parameter int TICK_W        = 32,
    parameter int SKIP_TH       = 8192,
    parameter int TICKS_PER_SEC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic              irq_en_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              irq_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [TICK_W-1:0] ticks_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              late_o,
    output logic              skip_o
);

    logic             cmp_we;
    logic [CMP_W-1:0] cmp_val;
    logic             pend_clr;
    logic             pend;
    logic             div_start;
    logic             div_done;
    logic [CNT_W-1:0] div_dividend;
    logic [CNT_W-1:0] div_divisor;
    logic [CNT_W-1:0] div_quo;
    logic [CNT_W-1:0] div_rem;

    itmr_counter #(
        .CNT_W (CNT_W),
        .CMP_W (CMP_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_we   (cmp_we),
        .cmp_val  (cmp_val),
        .pend_clr (pend_clr),
        .count_o  (count_o),
        .pend_o   (pend)
    );

    itmr_divider #(
        .W (CNT_W)
    ) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .done_o   (div_done),
        .quo_o    (div_quo),
        .rem_o    (div_rem)
    );

    itmr_resched #(
        .CNT_W         (CNT_W),
        .CMP_W         (CMP_W),
        .PER_W         (PER_W),
        .TICK_W        (TICK_W),
        .SKIP_TH       (SKIP_TH),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_resched (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ack_i        (ack_i),
        .period_i     (period_i),
        .count_i      (count_o),
        .div_done     (div_done),
        .div_quo      (div_quo),
        .div_rem      (div_rem),
        .div_start    (div_start),
        .div_dividend (div_dividend),
        .div_divisor  (div_divisor),
        .cmp_we       (cmp_we),
        .cmp_val      (cmp_val),
        .pend_clr     (pend_clr),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .ticks_o      (ticks_o),
        .late_o       (late_o),
        .skip_o       (skip_o)
    );

    assign irq_o = pend && irq_en_i;

    // R10: the completion strobe never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;

    localparam int CNT_W  = 64;
    localparam int CMP_W  = 16;
    localparam int PER_W  = 32;
    localparam int TICK_W = 32;
    localparam int SKIP   = 100;
    localparam int TPS    = 4;
    localparam longint unsigned PER = 300;

    logic              clk;
    logic              rst_n;
    logic              start_i;
    logic              ack_i;
    logic              irq_en_i;
    logic [PER_W-1:0]  period_i;
    logic              irq_o;
    logic [CNT_W-1:0]  count_o;
    logic [TICK_W-1:0] ticks_o;
    logic              busy_o;
    logic              done_o;
    logic              late_o;
    logic              skip_o;

    interval_timer #(
        .CNT_W         (CNT_W),
        .CMP_W         (CMP_W),
        .PER_W         (PER_W),
        .TICK_W        (TICK_W),
        .SKIP_TH       (SKIP),
        .TICKS_PER_SEC (TPS)
    ) u_interval_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ack_i    (ack_i),
        .irq_en_i (irq_en_i),
        .period_i (period_i),
        .irq_o    (irq_o),
        .count_o  (count_o),
        .ticks_o  (ticks_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .late_o   (late_o),
        .skip_o   (skip_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        longint unsigned ticks;
        bit              late;
        bit              skip;
    } exp_t;

    exp_t            sb_q[$];
    int              n_tests = 0;
    int              n_fail  = 0;
    int              n_push  = 0;
    int              n_done  = 0;
    bit              finished = 1'b0;
    longint unsigned exp_e;
    longint unsigned exp_cmp;

    task automatic chk(bit ok, string req, longint unsigned act, longint unsigned expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every completion strobe
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            exp_t e;
            n_done++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 completion without accepted ack", 1, 0);
            end else begin
                e = sb_q.pop_front();
                chk(ticks_o == TICK_W'(e.ticks), "R4 tick count", ticks_o, e.ticks);
                chk(late_o == e.late, "R7 late flag", late_o, e.late);
                chk(skip_o == e.skip, "R6 skip flag", skip_o, e.skip);
            end
        end
    end

    task automatic wait_irq();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!irq_o && guard < 20000);
        chk(irq_o, "R2 interrupt raised", irq_o, 1);
        chk((count_o - 1) == exp_cmp, "R2 R6 deadline cycle", count_o - 1, exp_cmp);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy_o && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // driver: acknowledges after a delay and pushes the expected result
    task automatic do_ack(int delay, bit hit_busy);
        longint unsigned now, el, qv, rv, left, nxt;
        exp_t e;
        repeat (delay) @(negedge clk);
        now     = count_o;
        ack_i   = 1'b1;
        el      = now - exp_e;
        qv      = el / PER;
        rv      = el % PER;
        left    = PER - rv;
        nxt     = now + left;
        e.ticks = qv + 1;
        e.late  = (qv + 1) > TPS;
        e.skip  = left < SKIP;
        exp_e   = nxt;
        exp_cmp = nxt + (e.skip ? PER : 0);
        sb_q.push_back(e);
        n_push++;
        @(negedge clk);
        ack_i = 1'b0;
        chk(!irq_o, "R4 pending cleared by ack", irq_o, 0);
        if (hit_busy) begin
            chk(busy_o, "R9 busy after accept", busy_o, 1);
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        longint unsigned c0;
        logic [TICK_W-1:0] held;
        rst_n    = 1'b0;
        start_i  = 1'b0;
        ack_i    = 1'b0;
        irq_en_i = 1'b1;
        period_i = PER_W'(PER);
        repeat (3) @(negedge clk);
        chk(count_o == 0, "R1 count in reset", count_o, 0);
        chk(!irq_o && !busy_o && !done_o, "R10 reset outputs", {irq_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count_o == 1, "R1 first step", count_o, 1);
        @(negedge clk);
        chk(count_o == 2, "R1 second step", count_o, 2);

        // R9: acknowledge before start does nothing
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o, "R9 ack before start ignored", busy_o, 0);

        // R2: arm the timer
        c0      = count_o;
        start_i = 1'b1;
        exp_e   = c0 + PER;
        exp_cmp = exp_e;
        @(negedge clk);
        start_i = 1'b0;

        wait_irq();
        do_ack(2, 1'b0);              // prompt ack, fast path, one tick
        wait_irq();
        do_ack(int'(PER) - 50, 1'b1); // R6 near boundary -> skip, R9 busy ack
        held = ticks_o;
        repeat (5) @(negedge clk);
        chk(ticks_o == held, "R10 results held", ticks_o, held);
        wait_irq();
        do_ack(3, 1'b0);              // R5 catch-up after skip: two ticks

        // R3: masked deadline keeps the pending flag
        irq_en_i = 1'b0;
        while (count_o != exp_cmp + 5) @(negedge clk);
        chk(!irq_o, "R3 masked interrupt low", irq_o, 0);
        irq_en_i = 1'b1;
        @(negedge clk);
        chk(irq_o, "R3 pending survives mask", irq_o, 1);
        do_ack(0, 1'b0);

        wait_irq();
        do_ack(1500, 1'b0);           // R7 late on subtraction path
        wait_irq();
        do_ack(10000, 1'b0);          // R8 general divider path
        wait_irq();
        do_ack(4, 1'b0);

        repeat (3) @(negedge clk);
        chk(n_done == n_push, "R9 one completion per accepted ack", n_done, n_push);
        chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule